// File: doc/BRIEF.md
# Floating-Point Pipeline Issue Interlock

This block sits beside the decode stage of an in-order, single-issue pipeline whose execution paths have unequal lengths: a one-stage integer ALU, a two-cycle load path, a four-stage pipelined FP adder, a seven-stage pipelined multiplier and a non-pipelined divider that is occupied for 25 cycles. Each cycle it looks at the instruction waiting in decode and either lets it issue or holds it, together with everything behind it, until every hazard has cleared.

Three kinds of hazard are judged. Structural hazards come from the divider, which takes one operation at a time, and from the single register-file write port. A reservation vector books the port for each issued instruction's write-back cycle, so no two writers ever land on it in the same cycle. Read-after-write hazards come from a per-register countdown of the cycles left until each result exists. Write-after-write hazards come from a long-latency operation that still owes a write to the same register. Instructions that write nothing are exempt from the port and WAW checks.

The per-register pending flags are brought out so that neighbouring logic (forwarding select, debug) can see which registers still await a result.

Top module: `fp_issue_interlock`

## Requirements
- R1: A synchronous, active-high reset clears all port reservations, every pending flag and the divider occupancy. While reset is high, stall and issue are low, and the first instruction after reset issues without stalling.
- R2: A valid instruction in decode with no hazard raises issue in the same cycle. When a hazard exists, stall is raised instead. Stall and issue are never high together, and both are low when decode holds no valid instruction.
- R3: The class code sets the write-back offset from the issue cycle: 0 = integer ALU, 1 cycle; 1 = load, 2 cycles; 2 = FP add, 4 cycles; 3 = multiply, 7 cycles; 4 = divide, 25 cycles. Codes 5 to 7 behave as the integer ALU.
- R4: The pending flag of an issued instruction's destination is high from the cycle after issue up to the cycle before its write-back offset expires, and low from the write-back cycle on. An ALU result therefore never shows as pending.
- R5: A valid instruction stalls while either of its enabled source registers is pending.
- R6: A writing instruction stalls when its own write-back cycle is already booked on the register write port by an issued instruction.
- R7: A divide stalls until 25 cycles have passed since the previous divide issued.
- R8: A writing instruction stalls while its destination is pending from an FP add, multiply or divide. A destination that is pending only from a load or ALU instruction raises no WAW stall.
- R9: An instruction with the write flag low skips the write-port and WAW checks. It still stalls on pending sources and on a busy divider.
- R10: The most recently issued writer of a register defines that register's pending time. After a load, a later FP add to the same register keeps it pending until the add's write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_cls | input | 3 | Unit class code (see R3) |
| dec_wr | input | 1 | Instruction writes a register |
| dec_dst | input | 5 | Destination register |
| dec_s1_en | input | 1 | First source is read |
| dec_s1 | input | 5 | First source register |
| dec_s2_en | input | 1 | Second source is read |
| dec_s2 | input | 5 | Second source register |
| stall | output | 1 | Hold decode and everything behind it |
| issue | output | 1 | Instruction in decode issues this cycle |
| pending | output | 32 | Per-register result-outstanding flags |

## Verification
The hard case is an instruction whose write-back collides with an earlier, longer operation's write-back in the same cycle. The bench provokes it by issuing a multiply, two ALU fillers and then an FP add that would land on the multiply's write-back cycle, and by placing an ALU instruction right after a load. Each case must cost exactly one stall cycle. A second coincidence is a register's pending flag being cleared by its write-back in the same cycle that a stalled reader or rewriter is released. The bench judges this against a behavioural reference model, which compares stall, issue and all pending flags on every clock and checks the stall count expected for each scenario instruction.

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock #(
  parameter int NREG  = 32,
  parameter int ALU_D = 1,
  parameter int LD_D  = 2,
  parameter int ADD_D = 4,
  parameter int MUL_D = 7,
  parameter int DIV_D = 25
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dec_valid,
  input  logic [2:0]              dec_cls,
  input  logic                    dec_wr,
  input  logic [$clog2(NREG)-1:0] dec_dst,
  input  logic                    dec_s1_en,
  input  logic [$clog2(NREG)-1:0] dec_s1,
  input  logic                    dec_s2_en,
  input  logic [$clog2(NREG)-1:0] dec_s2,
  output logic                    stall,
  output logic                    issue,
  output logic [NREG-1:0]         pending
);
  localparam int RA   = $clog2(NREG);
  localparam int MX1  = ALU_D > LD_D ? ALU_D : LD_D;
  localparam int MX2  = MX1 > ADD_D ? MX1 : ADD_D;
  localparam int MX3  = MX2 > MUL_D ? MX2 : MUL_D;
  localparam int MAXD = MX3 > DIV_D ? MX3 : DIV_D;
  localparam int RV   = MAXD + 1;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [2:0] C_LD = 3'd1, C_ADD = 3'd2, C_MUL = 3'd3, C_DIV = 3'd4;

  logic [RV-1:0]   resv_q;
  logic [CW-1:0]   rem_q [NREG];
  logic [NREG-1:0] long_q;
  logic [CW-1:0]   div_q;
  logic [CW-1:0]   d;
  logic            is_long, raw, port_hit, waw, div_busy, hazard, wr_go;

  always_comb begin
    case (dec_cls)
      C_LD:    d = CW'(LD_D);
      C_ADD:   d = CW'(ADD_D);
      C_MUL:   d = CW'(MUL_D);
      C_DIV:   d = CW'(DIV_D);
      default: d = CW'(ALU_D);
    endcase
  end

  assign is_long  = (dec_cls == C_ADD) | (dec_cls == C_MUL) | (dec_cls == C_DIV);
  assign raw      = (dec_s1_en & pending[dec_s1]) | (dec_s2_en & pending[dec_s2]);
  assign port_hit = dec_wr & resv_q[d];
  assign waw      = dec_wr & pending[dec_dst] & long_q[dec_dst];
  assign div_busy = (dec_cls == C_DIV) & (div_q != '0);
  assign hazard   = raw | port_hit | waw | div_busy;
  assign stall    = ~rst & dec_valid & hazard;
  assign issue    = ~rst & dec_valid & ~hazard;
  assign wr_go    = issue & dec_wr;

  always_ff @(posedge clk) begin
    if (rst) resv_q <= '0;
    else     resv_q <= (resv_q | (wr_go ? (RV'(1) << d) : RV'(0))) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst)                           div_q <= '0;
    else if (issue && dec_cls == C_DIV) div_q <= CW'(DIV_D - 1);
    else if (div_q != '0)               div_q <= div_q - CW'(1);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign pending[i] = |rem_q[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        rem_q[i]  <= '0;
        long_q[i] <= 1'b0;
      end else if (wr_go && dec_dst == RA'(i)) begin
        rem_q[i]  <= d - CW'(1);
        long_q[i] <= is_long;
      end else if (rem_q[i] != '0) begin
        rem_q[i]  <= rem_q[i] - CW'(1);
      end
    end
  end
endmodule

// File: rtl/fp_issue_interlock_chk.sv
module fp_issue_interlock_chk #(
  parameter int NREG = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [2:0]              dec_cls,
  input logic                    dec_wr,
  input logic [$clog2(NREG)-1:0] dec_dst,
  input logic                    dec_s1_en,
  input logic [$clog2(NREG)-1:0] dec_s1,
  input logic                    stall,
  input logic                    issue,
  input logic [NREG-1:0]         pending
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pending == '0));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(stall && issue));

  a_r4_mul_pending: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_wr && dec_cls == 3'd3) |=> pending[$past(dec_dst)]);

  a_r5_no_raw_issue: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_s1_en) |-> !pending[dec_s1]);

  a_r6_port_unique: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_wr && dec_cls == 3'd0) |-> !$past(issue && dec_wr && dec_cls == 3'd1));

  a_r7_div_gap: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_cls == 3'd4) |=> !(issue && dec_cls == 3'd4));
endmodule

bind fp_issue_interlock fp_issue_interlock_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .dec_cls(dec_cls), .dec_wr(dec_wr), .dec_dst(dec_dst),
  .dec_s1_en(dec_s1_en), .dec_s1(dec_s1), .stall(stall), .issue(issue),
  .pending(pending)
);

// File: tb/fp_issue_interlock_bench.sv
module fp_issue_interlock_bench;
  logic        clk = 1'b0, rst = 1'b1;
  logic        dec_valid = 1'b0, dec_wr = 1'b0, dec_s1_en = 1'b0, dec_s2_en = 1'b0;
  logic [2:0]  dec_cls = '0;
  logic [4:0]  dec_dst = '0, dec_s1 = '0, dec_s2 = '0;
  logic        stall, issue;
  logic [31:0] pending;

  always #4 clk = ~clk;

  fp_issue_interlock u_fp_issue_interlock (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_cls(dec_cls), .dec_wr(dec_wr),
    .dec_dst(dec_dst), .dec_s1_en(dec_s1_en), .dec_s1(dec_s1), .dec_s2_en(dec_s2_en),
    .dec_s2(dec_s2), .stall(stall), .issue(issue), .pending(pending)
  );

  typedef struct {
    bit v; bit [2:0] c; bit w; int d; bit e1; int s1; bit e2; int s2; int xs; string tag;
  } ins_t;
  typedef struct { int dst; int wb; bit lng; } rec_t;

  ins_t prog[$];
  rec_t rq[$];
  int   cyc = 0, last_div = -1000;
  int   n_cmp = 0, n_bad = 0;

  function automatic int depth(bit [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 7;
      3'd4: return 25;
      default: return 1;
    endcase
  endfunction

  function automatic bit pend(int r);
    for (int i = rq.size() - 1; i >= 0; i--)
      if (rq[i].dst == r) return rq[i].wb > cyc;
    return 1'b0;
  endfunction

  function automatic bit pend_long(int r);
    for (int i = rq.size() - 1; i >= 0; i--)
      if (rq[i].dst == r) return rq[i].lng && (rq[i].wb > cyc);
    return 1'b0;
  endfunction

  function automatic bit port_booked(int c);
    foreach (rq[i]) if (rq[i].wb == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic add(bit [2:0] c, bit w, int d, bit e1, int s1, bit e2, int s2, int xs, string tag);
    ins_t x;
    x.v = 1; x.c = c; x.w = w; x.d = d; x.e1 = e1; x.s1 = s1; x.e2 = e2; x.s2 = s2;
    x.xs = xs; x.tag = tag;
    prog.push_back(x);
  endtask

  task automatic bubble(int n);
    ins_t x;
    x.v = 0; x.c = 0; x.w = 0; x.d = 0; x.e1 = 0; x.s1 = 0; x.e2 = 0; x.s2 = 0;
    x.xs = -1; x.tag = "R2";
    for (int i = 0; i < n; i++) prog.push_back(x);
  endtask

  task automatic run_prog();
    int idx = 0, stalls = 0;
    while (idx < prog.size()) begin
      ins_t x;
      bit exp_st, exp_is;
      logic [31:0] exp_p;
      x = prog[idx];
      @(negedge clk);
      dec_valid = x.v; dec_cls = x.c; dec_wr = x.w; dec_dst = 5'(x.d);
      dec_s1_en = x.e1; dec_s1 = 5'(x.s1); dec_s2_en = x.e2; dec_s2 = 5'(x.s2);
      #1;
      exp_st = x.v && ((x.e1 && pend(x.s1)) || (x.e2 && pend(x.s2)) ||
                       (x.c == 3'd4 && cyc < last_div + 25) ||
                       (x.w && port_booked(cyc + depth(x.c))) ||
                       (x.w && pend_long(x.d)));
      exp_is = x.v && !exp_st;
      for (int r = 0; r < 32; r++) exp_p[r] = pend(r);
      check(stall === exp_st, x.tag, "stall", int'(stall), int'(exp_st));
      check(issue === exp_is, x.tag, "issue", int'(issue), int'(exp_is));
      check(pending === exp_p, "R4", "pending", int'(pending), int'(exp_p));
      if (stall) stalls++;
      if (exp_is) begin
        rec_t rr;
        if (x.w) begin
          rr.dst = x.d; rr.wb = cyc + depth(x.c); rr.lng = x.c inside {3'd2, 3'd3, 3'd4};
          rq.push_back(rr);
        end
        if (x.c == 3'd4) last_div = cyc;
        if (x.xs >= 0) check(stalls == x.xs, x.tag, "stall cycles", stalls, x.xs);
      end
      cyc++;
      if (exp_is || !x.v) begin idx++; stalls = 0; end
    end
    prog.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    dec_valid = 0; rst = 1;
    repeat (2) @(negedge clk);
    #1;
    check(stall === 1'b0 && issue === 1'b0, "R1", "outputs in reset", int'({stall, issue}), 0);
    rst = 0;
    rq.delete(); cyc = 0; last_div = -1000;
    #1;
    check(pending === '0, "R1", "pending after reset", int'(pending), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // divider occupancy (R7) and a non-writing divide while busy (R9)
    add(3'd4, 1, 1, 1, 2, 1, 3, 0, "R1 R7");
    add(3'd4, 1, 4, 0, 0, 0, 0, 24, "R7");
    add(3'd4, 0, 0, 0, 0, 0, 0, 24, "R9");
    bubble(30);
    // multiply and add that collide on the write port (R3, R6)
    add(3'd3, 1, 5, 0, 0, 0, 0, 0, "R3");
    add(3'd0, 1, 20, 0, 0, 0, 0, 0, "R3");
    add(3'd0, 1, 21, 0, 0, 0, 0, 0, "R3");
    add(3'd2, 1, 6, 0, 0, 0, 0, 1, "R3 R6");
    bubble(10);
    // load then ALU on the same write-back cycle (R6)
    add(3'd1, 1, 11, 0, 0, 0, 0, 0, "R6");
    add(3'd0, 1, 12, 0, 0, 0, 0, 1, "R6");
    bubble(5);
    // WAW: add then load to same register (R8)
    add(3'd2, 1, 7, 0, 0, 0, 0, 0, "R8");
    add(3'd1, 1, 7, 0, 0, 0, 0, 3, "R8");
    bubble(5);
    // load then add to same register: no WAW, add defines pending (R8, R10)
    add(3'd1, 1, 9, 0, 0, 0, 0, 0, "R10");
    add(3'd2, 1, 9, 0, 0, 0, 0, 0, "R8 R10");
    add(3'd0, 1, 13, 1, 9, 0, 0, 3, "R10");
    bubble(5);
    // RAW on multiply result, second source port (R5)
    add(3'd3, 1, 10, 0, 0, 0, 0, 0, "R5");
    add(3'd0, 1, 14, 1, 1, 1, 10, 6, "R5");
    bubble(5);
    // non-writing store over pending destination, then reading it (R9)
    add(3'd2, 1, 17, 0, 0, 0, 0, 0, "R9");
    add(3'd0, 0, 17, 0, 0, 0, 0, 0, "R9");
    add(3'd0, 0, 0, 1, 17, 0, 0, 2, "R9");
    add(3'd5, 1, 18, 0, 0, 0, 0, 0, "R3");
    add(3'd0, 1, 19, 1, 18, 0, 0, 0, "R3 R4");
    bubble(8);
    add(3'd3, 1, 3, 0, 0, 0, 0, 0, "R2");
    add(3'd4, 1, 22, 0, 0, 0, 0, 0, "R2");
    run_prog();
    do_reset();
    add(3'd0, 1, 23, 1, 3, 1, 22, 0, "R1");
    add(3'd4, 1, 24, 0, 0, 0, 0, 0, "R1");
    bubble(3);
    run_prog();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule